// File: doc/BRIEF.md
# Battery Capacity LED Display Driver

This block turns a remaining-capacity percentage (0 to 125) into a pattern on five LED segment outputs plus one common-source enable. A two-bit code, standing for a three-level strap, picks one of three display styles. They are single-segment incremental, two-segment binary and five-segment bar graph. Each style has its own percentage thresholds and its own display-on time.

An active-low display request opens a timed window, and the LEDs are lit only inside that window. A low-battery flag makes segment 1 blink at 4 Hz in the incremental and bar-graph styles. A failure flag blanks everything. To keep average current low, the lit segments are strobed in two banks. Segments 1, 3 and 5 form one bank and segments 2 and 4 the other. Each bank is on for 30 % of a 100 Hz period, and the two banks never overlap. All timing is derived from the `CLK_HZ` parameter.

Top module: `capgauge_led_driver`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `seg_on` is 0 and `led_com` is 0. The blink square wave restarts in its high half.
- R2: When `mode_sel` = 2'b00 (incremental), exactly one segment is selected. Bit 3 is selected for pct >= 90, bit 2 for 50..89, bit 1 for 20..49 and bit 0 for pct < 20. Bit 0 of `seg_on` is segment 1.
- R3: When `mode_sel` = 2'b01 (binary), only bits 0 and 1 are used. Both are selected for pct >= 70, bit 0 alone for 40..69, bit 1 alone for 10..39, and none for pct < 10.
- R4: When `mode_sel` = 2'b10 or 2'b11 (bar graph), the lowest n bits are selected. n is 5 for pct >= 80, 4 for 60..79, 3 for 40..59, 2 for 20..39 and 1 below 20.
- R5: A low `disp_req_n` sampled on a clock edge loads the window with 10·CLK_HZ cycles in incremental mode and 4·CLK_HZ cycles otherwise. The outputs are active from the next edge until the window count runs out. A new request restarts the count.
- R6: With no window open, `seg_on` and `led_com` stay 0 whatever the other inputs are.
- R7: With `low_flag` set in incremental or bar-graph mode, only bit 0 is selected, and only during the high half of a 4 Hz square wave. In binary mode `low_flag` has no effect.
- R8: With `fail_flag` set, every segment and `led_com` are 0 on the next cycle, in every mode.
- R9: With strobe period P = CLK_HZ/100 and on-length L = P·30/100, bits 0, 2 and 4 may be driven only at strobe phases 0..L-1. Bits 1 and 3 may be driven only at phases P/2..P/2+L-1.
- R10: `led_com` is 1 exactly while a window is open and `fail_flag` is clear. A segment is never driven while `led_com` is 0.
- R11: Percentages from 101 to 125 display the same as the top band of the selected mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Display style: 00 incremental, 01 binary, 10/11 bar graph |
| pct | input | PCT_W | Remaining capacity in percent, 0..125 |
| disp_req_n | input | 1 | Active-low display request |
| low_flag | input | 1 | First-empty (low battery) flag |
| fail_flag | input | 1 | Final-empty (failure) flag |
| seg_on | output | 5 | Segment drive, 1 = LED on; bit 0 is segment 1 |
| led_com | output | 1 | Common LED source enable, 0 = high impedance |

## Verification
On every cycle, the assertions check several properties. The two banks are never driven together. No segment is driven without the common source. A failure flag blanks the next cycle, and a request always opens a window. The incremental decode stays one-hot, binary mode never reaches the upper three bits, and the blink wave changes only on its counter wrap. Other behaviours can be shown only by the bench's scenarios run against its cycle-level model. These are the exact threshold bands of each style and the exact window length in each mode. They also include the restart on a repeated request, the 4 Hz blink phase, and percentages above 100.

// File: rtl/capgauge_pkg.sv
package capgauge_pkg;
  localparam int SEG_N = 5;

  typedef enum logic [1:0] {
    DM_INC     = 2'b00,
    DM_BIN     = 2'b01,
    DM_BAR     = 2'b10,
    DM_BAR_ALT = 2'b11
  } disp_mode_t;

  // band edges in percent
  localparam int INC_T3 = 90, INC_T2 = 50, INC_T1 = 20;
  localparam int BIN_T2 = 70, BIN_T1 = 40, BIN_T0 = 10;
  localparam int BAR_T4 = 80, BAR_T3 = 60, BAR_T2 = 40, BAR_T1 = 20;
endpackage

// File: rtl/cg_ticks.sv
module cg_ticks #(
  parameter int PERIOD     = 327,
  parameter int ON_LEN     = 98,
  parameter int HALF_BLINK = 4096
) (
  input  logic clk,
  input  logic rst,
  output logic bank_a,
  output logic bank_b,
  output logic blink_sq
);
  localparam int SW = $clog2(PERIOD + 1);
  localparam int BW = $clog2(HALF_BLINK + 1);
  localparam int B_START = PERIOD / 2;

  logic [SW-1:0] phase;
  logic [BW-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= '0;
      bcnt     <= '0;
      blink_sq <= 1'b1;
    end else begin
      phase <= (phase == SW'(PERIOD - 1)) ? '0 : phase + 1'b1;
      if (bcnt == BW'(HALF_BLINK - 1)) begin
        bcnt     <= '0;
        blink_sq <= ~blink_sq;
      end else begin
        bcnt <= bcnt + 1'b1;
      end
    end
  end

  assign bank_a = (phase < SW'(ON_LEN));
  assign bank_b = (phase >= SW'(B_START)) && (phase < SW'(B_START + ON_LEN));

  AST_BLINK_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
    !$stable(blink_sq) |-> (bcnt == '0)); // R7
endmodule

// File: rtl/cg_window.sv
module cg_window #(
  parameter int DUR_INC = 327680,
  parameter int DUR_OTH = 131072
) (
  input  logic clk,
  input  logic rst,
  input  logic req_n,
  input  logic is_inc,
  output logic active
);
  localparam int WW = $clog2(DUR_INC + 1);

  logic [WW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      left <= '0;
    end else if (!req_n) begin
      left <= is_inc ? WW'(DUR_INC) : WW'(DUR_OTH);
    end else if (left != '0) begin
      left <= left - 1'b1;
    end
  end

  assign active = (left != '0);

  AST_REQ_OPENS_WINDOW: assert property (@(posedge clk) disable iff (rst)
    !req_n |=> active); // R5
endmodule

// File: rtl/cg_pattern.sv
module cg_pattern
  import capgauge_pkg::*;
#(
  parameter int PCT_W = 7
) (
  input  disp_mode_t       mode,
  input  logic [PCT_W-1:0] pct,
  input  logic             low_flag,
  input  logic             blink_sq,
  output logic [SEG_N-1:0] pat
);
  always_comb begin
    pat = '0;
    unique case (mode)
      DM_INC: begin
        if (low_flag)                 pat = {4'b0000, blink_sq};
        else if (pct >= PCT_W'(INC_T3)) pat = 5'b01000;
        else if (pct >= PCT_W'(INC_T2)) pat = 5'b00100;
        else if (pct >= PCT_W'(INC_T1)) pat = 5'b00010;
        else                          pat = 5'b00001;
      end
      DM_BIN: begin
        if (pct >= PCT_W'(BIN_T2))      pat = 5'b00011;
        else if (pct >= PCT_W'(BIN_T1)) pat = 5'b00001;
        else if (pct >= PCT_W'(BIN_T0)) pat = 5'b00010;
        else                          pat = 5'b00000;
      end
      DM_BAR, DM_BAR_ALT: begin
        if (low_flag)                 pat = {4'b0000, blink_sq};
        else if (pct >= PCT_W'(BAR_T4)) pat = 5'b11111;
        else if (pct >= PCT_W'(BAR_T3)) pat = 5'b01111;
        else if (pct >= PCT_W'(BAR_T2)) pat = 5'b00111;
        else if (pct >= PCT_W'(BAR_T1)) pat = 5'b00011;
        else                          pat = 5'b00001;
      end
      default: pat = '0;
    endcase
  end
endmodule

// File: rtl/capgauge_led_driver.sv
module capgauge_led_driver
  import capgauge_pkg::*;
#(
  parameter int CLK_HZ    = 32768,
  parameter int STROBE_HZ = 100,
  parameter int DUTY_PCT  = 30,
  parameter int BLINK_HZ  = 4,
  parameter int WIN_INC_S = 10,
  parameter int WIN_OTH_S = 4,
  parameter int PCT_W     = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_sel,
  input  logic [PCT_W-1:0] pct,
  input  logic             disp_req_n,
  input  logic             low_flag,
  input  logic             fail_flag,
  output logic [SEG_N-1:0] seg_on,
  output logic             led_com
);
  localparam int PERIOD     = CLK_HZ / STROBE_HZ;
  localparam int ON_LEN     = PERIOD * DUTY_PCT / 100;
  localparam int HALF_BLINK = CLK_HZ / (2 * BLINK_HZ);
  localparam int DUR_INC    = WIN_INC_S * CLK_HZ;
  localparam int DUR_OTH    = WIN_OTH_S * CLK_HZ;

  disp_mode_t       mode;
  logic             bank_a, bank_b, blink_sq, win_open, show;
  logic [SEG_N-1:0] pat, mask;

  assign mode = disp_mode_t'(mode_sel);

  cg_ticks #(.PERIOD(PERIOD), .ON_LEN(ON_LEN), .HALF_BLINK(HALF_BLINK)) u_ticks (
    .clk(clk), .rst(rst), .bank_a(bank_a), .bank_b(bank_b), .blink_sq(blink_sq));

  cg_window #(.DUR_INC(DUR_INC), .DUR_OTH(DUR_OTH)) u_window (
    .clk(clk), .rst(rst), .req_n(disp_req_n), .is_inc(mode == DM_INC), .active(win_open));

  cg_pattern #(.PCT_W(PCT_W)) u_pattern (
    .mode(mode), .pct(pct), .low_flag(low_flag), .blink_sq(blink_sq), .pat(pat));

  // even index (segments 1,3,5) on bank A, odd index (segments 2,4) on bank B
  for (genvar i = 0; i < SEG_N; i++) begin : g_bank
    if (i % 2 == 0) begin : g_a
      assign mask[i] = bank_a;
    end else begin : g_b
      assign mask[i] = bank_b;
    end
  end

  assign show = win_open && !fail_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_on  <= '0;
      led_com <= 1'b0;
    end else begin
      seg_on  <= show ? (pat & mask) : '0;
      led_com <= show;
    end
  end

  AST_FAIL_BLANKS: assert property (@(posedge clk) disable iff (rst)
    fail_flag |=> (seg_on == '0 && !led_com)); // R8
  AST_SEG_NEEDS_COM: assert property (@(posedge clk) disable iff (rst)
    (seg_on != '0) |-> led_com); // R10
  AST_BANKS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !((|(seg_on & 5'b10101)) && (|(seg_on & 5'b01010)))); // R9
  AST_INC_ONE_SELECTED: assert property (@(posedge clk) disable iff (rst)
    (mode == DM_INC && !low_flag) |-> $onehot(pat)); // R2
  AST_BIN_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
    (mode == DM_BIN) |-> (pat[4:2] == 3'b000)); // R3
endmodule

// File: tb/capgauge_led_driver_test.sv
module capgauge_led_driver_test;
  localparam int HZ = 2000;
  localparam int P  = HZ / 100;
  localparam int L  = P * 30 / 100;
  localparam int H  = HZ / 8;
  localparam int DI = 10 * HZ;
  localparam int DO = 4 * HZ;

  logic       clk = 0, rst = 1;
  logic [1:0] mode_sel = 2'b00;
  logic [6:0] pct = 7'd0;
  logic       disp_req_n = 1, low_flag = 0, fail_flag = 0;
  logic [4:0] seg_on;
  logic       led_com;

  capgauge_led_driver #(.CLK_HZ(HZ)) uut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .pct(pct), .disp_req_n(disp_req_n),
    .low_flag(low_flag), .fail_flag(fail_flag), .seg_on(seg_on), .led_com(led_com));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  string tag = "R1";
  bit started = 0;
  int ms, mb, mw, es, ec;
  bit msq;

  function automatic int model_pat(int m, int p, bit lo, bit sq);
    int n;
    if (m == 1) begin
      if (p >= 70) return 3;
      if (p >= 40) return 1;
      if (p >= 10) return 2;
      return 0;
    end
    if (lo) return sq ? 1 : 0;
    if (m == 0) begin
      n = (p >= 90) ? 3 : (p >= 50) ? 2 : (p >= 20) ? 1 : 0;
      return 1 << n;
    end
    n = (p >= 80) ? 5 : (p >= 60) ? 4 : (p >= 40) ? 3 : (p >= 20) ? 2 : 1;
    return (1 << n) - 1;
  endfunction

  // behavioural reference, advanced once per rising edge
  always @(posedge clk) begin
    int msk;
    started <= 1;
    if (rst) begin
      ms = 0; mb = 0; msq = 1; mw = 0; es = 0; ec = 0;
    end else begin
      msk = 0;
      if (ms < L) msk |= 5'b10101;
      if (ms >= P/2 && ms < P/2 + L) msk |= 5'b01010;
      ec = (mw > 0 && !fail_flag) ? 1 : 0;
      es = ec ? (model_pat(mode_sel, pct, low_flag, msq) & msk) : 0;
      ms = (ms + 1) % P;
      if (mb == H - 1) begin mb = 0; msq = !msq; end else mb++;
      if (!disp_req_n) mw = (mode_sel == 2'b00) ? DI : DO;
      else if (mw > 0) mw--;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (seg_on !== 5'(es) || led_com !== 1'(ec)) begin
        errors++;
        $display("FAIL %s: seg_on=%b led_com=%b expected seg_on=%b led_com=%b",
                 tag, seg_on, led_com, 5'(es), 1'(ec));
      end
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic request();
    disp_req_n = 0;
    run(1);
    disp_req_n = 1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected below 190000", cycles);
      finish_run();
    end
  end

  initial begin
    tag = "R1"; run(5);
    rst = 0;
    tag = "R6"; pct = 7'd95; low_flag = 1; run(200); low_flag = 0;
    // incremental bands and full 10 s window
    tag = "R2"; mode_sel = 2'b00; request();
    foreach (pct_list_inc[k]) begin pct = pct_list_inc[k]; run(600); end
    tag = "R11"; pct = 7'd125; run(600);
    tag = "R5"; run(DI - 3000);
    tag = "R10"; run(200);
    // restart during an open window
    tag = "R5"; pct = 7'd60; request(); run(DI / 2); request(); run(DI - 100);
    tag = "R10"; run(300);
    // binary bands, low flag has no effect
    tag = "R3"; mode_sel = 2'b01; request();
    foreach (pct_list_bin[k]) begin pct = pct_list_bin[k]; run(400); end
    tag = "R7"; low_flag = 1; pct = 7'd75; run(400); low_flag = 0;
    tag = "R11"; pct = 7'd110; run(300);
    // bar graph on both codes
    tag = "R4"; mode_sel = 2'b10; request();
    foreach (pct_list_bar[k]) begin pct = pct_list_bar[k]; run(400); end
    tag = "R9"; pct = 7'd100; run(200);
    tag = "R4"; mode_sel = 2'b11; pct = 7'd45; run(300);
    tag = "R11"; pct = 7'd125; run(300);
    // blink in bar and incremental
    tag = "R7"; mode_sel = 2'b10; pct = 7'd90; low_flag = 1; request(); run(1500);
    mode_sel = 2'b00; request(); run(1500); low_flag = 0;
    // failure blanks everything
    tag = "R8"; fail_flag = 1; run(300);
    mode_sel = 2'b01; request(); run(300); fail_flag = 0;
    tag = "R10"; run(DO + 100);
    tag = "R6"; run(300);
    // reset mid-window
    tag = "R1"; mode_sel = 2'b10; request(); run(100); rst = 1; run(3); rst = 0; run(50);
    finish_run();
  end

  logic [6:0] pct_list_inc [6] = '{7'd100, 7'd90, 7'd89, 7'd50, 7'd49, 7'd19};
  logic [6:0] pct_list_bin [7] = '{7'd70, 7'd69, 7'd40, 7'd39, 7'd10, 7'd9, 7'd0};
  logic [6:0] pct_list_bar [9] = '{7'd80, 7'd79, 7'd60, 7'd59, 7'd40, 7'd39, 7'd20, 7'd19, 7'd0};
endmodule